// File: doc/BRIEF.md
# Pin Test Vector Applier and Checker

This block replays functional test vectors against a logic device under test. Each vector carries one 4-bit symbol per device pin and is accepted with a valid/ready handshake. A symbol either drives the pin (steady levels, clock pulses, single edges), releases the tester's drive, or states what the device should show on the pin. The block steps through a fixed sequence for every vector. It applies the steady levels, waits a programmable settle count, runs a three-cycle clock phase, waits the settle count again, then samples the device and compares.

Steady levels always land before any clock-type symbol moves, so a register inside the device sees its data set up before the clock edge that captures it. The device reports its own per-pin output value and output enable. A high-impedance expectation is judged from that enable. Each vector ends with a one-cycle result pulse that carries a pass flag and a per-pin mismatch mask. A running counter records how many vectors have failed.

Top module: `vec_player`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pin_drv_en` is all zero, `fail_count` is 0, `res_valid` is 0 and `vec_ready` is 1.
- R2: Pin i uses symbol bits [4i+3:4i]. Code 0 drives the pin low and code 1 drives it high, each with the drive enable set, during the level phase.
- R3: Every code-0/1 level of a vector is applied before any clock-type pin (codes 2 to 5) changes, and a settle wait lies between them. A device register whose data and clock change in the same vector captures the new data.
- R4: Code 2 makes the pin go low, then high, then low within the vector. From a low start this gives exactly one rising edge, and the pin ends low with its drive enabled.
- R5: Code 3 makes the pin go high, then low, then high within the vector. The pin ends high with its drive enabled.
- R6: Code 4 leaves the pin high and code 5 leaves it low, with a single edge. Combinational device outputs fed by the pin show the new level when the vector is compared.
- R7: Codes 6 (don't-care) and 7 (float), the expectation codes 8, 9 and 10, and the unused codes 11 to 15 all clear the pin's drive enable. Codes 6, 7 and 11 to 15 are never compared, so no pin is driven by both sides.
- R8: Code 8 passes only when the device output enable is 1 and its output is 0. Code 9 passes only when the output enable is 1 and its output is 1. Code 10 passes only when the output enable is 0. Mismatch bit i is set for each pin that fails.
- R9: A pin's drive level holds its last applied value between vectors and through vectors that release the pin.
- R10: The result follows the accepting clock edge by exactly 2*S+7 cycles, where S is the settle count. `vec_ready` is low from the accept until the result.
- R11: `res_valid` is a single-cycle pulse, and `res_pass` is 1 exactly when `res_mismatch` is zero.
- R12: `fail_count` rises by one with each failing result and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Block idle, vector taken when valid is also high |
| vec_syms | input | NPINS*4 | Symbol codes, pin i at bits [4i+3:4i] |
| settle_cnt | input | SETTLE_W | Settle wait for this vector |
| pin_drv | output | NPINS | Tester drive level per pin |
| pin_drv_en | output | NPINS | Tester drive enable per pin |
| dut_out | input | NPINS | Device output value per pin |
| dut_oe | input | NPINS | Device output enable per pin |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Vector passed |
| res_mismatch | output | NPINS | Per-pin mismatch mask |
| fail_count | output | FAIL_W | Number of failing vectors since reset |

## Verification
Two actions can meet inside one vector: a data pin changes level and the clock pin of the device register that samples it pulses or steps. The bench models that register, then sends vectors where the data pin flips while the clock pin carries a pulse, a rising step or a double-high pulse. It judges the result by the value the register presents on its output pin, which must be the new data. A second meeting point is the result pulse and the failure-counter step. The scoreboard checks the counter on the same strobe as each failing result.

// File: rtl/vec_player_pkg.sv
package vec_player_pkg;

  localparam int SYM_W = 4;

  typedef enum logic [SYM_W-1:0] {
    SYM_LO      = 4'd0,
    SYM_HI      = 4'd1,
    SYM_PULSE_C = 4'd2,
    SYM_PULSE_K = 4'd3,
    SYM_EDGE_U  = 4'd4,
    SYM_EDGE_D  = 4'd5,
    SYM_DCARE   = 4'd6,
    SYM_FLOAT   = 4'd7,
    SYM_EXP_LO  = 4'd8,
    SYM_EXP_HI  = 4'd9,
    SYM_EXP_Z   = 4'd10
  } sym_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_APPLY,
    PH_WAIT1,
    PH_CLK0,
    PH_CLK1,
    PH_CLK2,
    PH_WAIT2,
    PH_SAMPLE
  } phase_e;

endpackage

// File: rtl/vec_pin_lane.sv
module vec_pin_lane
  import vec_player_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase,
  input  logic [SYM_W-1:0] sym,
  output logic             drv,
  output logic             drv_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv    <= 1'b0;
      drv_en <= 1'b0;
    end else begin
      case (phase)
        PH_APPLY: begin
          case (sym)
            SYM_LO: begin
              drv    <= 1'b0;
              drv_en <= 1'b1;
            end
            SYM_HI: begin
              drv    <= 1'b1;
              drv_en <= 1'b1;
            end
            SYM_PULSE_C, SYM_PULSE_K, SYM_EDGE_U, SYM_EDGE_D: begin
            end
            default: drv_en <= 1'b0;
          endcase
        end
        PH_CLK0: begin
          if (sym == SYM_PULSE_C) begin
            drv    <= 1'b0;
            drv_en <= 1'b1;
          end else if (sym == SYM_PULSE_K) begin
            drv    <= 1'b1;
            drv_en <= 1'b1;
          end
        end
        PH_CLK1: begin
          if (sym == SYM_PULSE_C || sym == SYM_EDGE_U) begin
            drv    <= 1'b1;
            drv_en <= 1'b1;
          end else if (sym == SYM_PULSE_K || sym == SYM_EDGE_D) begin
            drv    <= 1'b0;
            drv_en <= 1'b1;
          end
        end
        PH_CLK2: begin
          if (sym == SYM_PULSE_C) drv <= 1'b0;
          else if (sym == SYM_PULSE_K) drv <= 1'b1;
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/vec_pin_judge.sv
module vec_pin_judge
  import vec_player_pkg::*;
#(
  parameter int NPINS = 6
) (
  input  logic [NPINS*SYM_W-1:0] syms,
  input  logic [NPINS-1:0]       dut_out,
  input  logic [NPINS-1:0]       dut_oe,
  output logic [NPINS-1:0]       mismatch
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [SYM_W-1:0] s;
    assign s = syms[i*SYM_W +: SYM_W];
    always_comb begin
      case (s)
        SYM_EXP_LO: mismatch[i] = !(dut_oe[i] && !dut_out[i]);
        SYM_EXP_HI: mismatch[i] = !(dut_oe[i] && dut_out[i]);
        SYM_EXP_Z:  mismatch[i] = dut_oe[i];
        default:    mismatch[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/vec_player.sv
module vec_player
  import vec_player_pkg::*;
#(
  parameter int NPINS    = 6,
  parameter int SETTLE_W = 8,
  parameter int FAIL_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vec_valid,
  output logic                   vec_ready,
  input  logic [NPINS*SYM_W-1:0] vec_syms,
  input  logic [SETTLE_W-1:0]    settle_cnt,
  output logic [NPINS-1:0]       pin_drv,
  output logic [NPINS-1:0]       pin_drv_en,
  input  logic [NPINS-1:0]       dut_out,
  input  logic [NPINS-1:0]       dut_oe,
  output logic                   res_valid,
  output logic                   res_pass,
  output logic [NPINS-1:0]       res_mismatch,
  output logic [FAIL_W-1:0]      fail_count
);

  localparam int VEC_W = NPINS * SYM_W;

  phase_e              phase;
  logic [VEC_W-1:0]    syms_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [SETTLE_W-1:0] wait_left;
  logic [NPINS-1:0]    mis_now;

  assign vec_ready = (phase == PH_IDLE);

  // Phase sequencer: level, settle, three clock steps, settle, sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      syms_q    <= '0;
      settle_q  <= '0;
      wait_left <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (vec_valid) begin
          syms_q   <= vec_syms;
          settle_q <= settle_cnt;
          phase    <= PH_APPLY;
        end
        PH_APPLY: begin
          wait_left <= settle_q;
          phase     <= PH_WAIT1;
        end
        PH_WAIT1: begin
          if (wait_left == '0) phase <= PH_CLK0;
          else wait_left <= wait_left - 1'b1;
        end
        PH_CLK0: phase <= PH_CLK1;
        PH_CLK1: phase <= PH_CLK2;
        PH_CLK2: begin
          wait_left <= settle_q;
          phase     <= PH_WAIT2;
        end
        PH_WAIT2: begin
          if (wait_left == '0) phase <= PH_SAMPLE;
          else wait_left <= wait_left - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_lane
    vec_pin_lane u_lane (
      .clk    (clk),
      .rst    (rst),
      .phase  (phase),
      .sym    (syms_q[i*SYM_W +: SYM_W]),
      .drv    (pin_drv[i]),
      .drv_en (pin_drv_en[i])
    );
  end

  vec_pin_judge #(.NPINS(NPINS)) u_judge (
    .syms     (syms_q),
    .dut_out  (dut_out),
    .dut_oe   (dut_oe),
    .mismatch (mis_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_pass     <= 1'b0;
      res_mismatch <= '0;
      fail_count   <= '0;
    end else begin
      res_valid <= (phase == PH_SAMPLE);
      if (phase == PH_SAMPLE) begin
        res_pass     <= (mis_now == '0);
        res_mismatch <= mis_now;
        if (mis_now != '0) fail_count <= fail_count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vec_player_chk.sv
module vec_player_chk #(
  parameter int NPINS  = 6,
  parameter int FAIL_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [NPINS-1:0]  pin_drv,
  input logic [NPINS-1:0]  pin_drv_en,
  input logic              res_valid,
  input logic              res_pass,
  input logic [NPINS-1:0]  res_mismatch,
  input logic [FAIL_W-1:0] fail_count
);

  // R11
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R11
  pass_mask_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_pass == (res_mismatch == '0)));

  // R12
  fail_step_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_pass) |-> fail_count == $past(fail_count) + 1'b1);

  // R12
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && !res_pass) |-> fail_count == $past(fail_count));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_ready) |=> !vec_ready);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    vec_ready |=> ($stable(pin_drv) && $stable(pin_drv_en)));

endmodule

bind vec_player vec_player_chk #(.NPINS(NPINS), .FAIL_W(FAIL_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .vec_valid    (vec_valid),
  .vec_ready    (vec_ready),
  .pin_drv      (pin_drv),
  .pin_drv_en   (pin_drv_en),
  .res_valid    (res_valid),
  .res_pass     (res_pass),
  .res_mismatch (res_mismatch),
  .fail_count   (fail_count)
);

// File: tb/test_vec_player.sv
module test_vec_player;
  localparam int NP = 6;
  localparam int SW = 8;
  localparam int FW = 16;

  localparam logic [3:0] C0 = 4'd0, C1 = 4'd1, CC = 4'd2, CK = 4'd3, CU = 4'd4,
                         CD = 4'd5, CX = 4'd6, CF = 4'd7, CL = 4'd8, CH = 4'd9,
                         CZ = 4'd10, CBAD = 4'd15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             vec_valid = 1'b0;
  logic             vec_ready;
  logic [NP*4-1:0]  vec_syms = '0;
  logic [SW-1:0]    settle_cnt = '0;
  logic [NP-1:0]    pin_drv, pin_drv_en, dut_out, dut_oe, res_mismatch;
  logic             res_valid, res_pass;
  logic [FW-1:0]    fail_count;

  vec_player #(.NPINS(NP), .SETTLE_W(SW), .FAIL_W(FW)) i_vec_player (
    .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_syms(vec_syms), .settle_cnt(settle_cnt), .pin_drv(pin_drv),
    .pin_drv_en(pin_drv_en), .dut_out(dut_out), .dut_oe(dut_oe),
    .res_valid(res_valid), .res_pass(res_pass), .res_mismatch(res_mismatch),
    .fail_count(fail_count));

  // Device model: pin0 data, pin1 clock, pin2 register out, pin3 = pin0^pin1,
  // pin4 enable for pin5, pin5 bidirectional register out.
  logic [NP-1:0] eff;
  logic q = 1'b0;
  int rises = 0;
  assign eff = pin_drv & pin_drv_en;
  always @(posedge eff[1]) begin
    q <= eff[0];
    rises <= rises + 1;
  end
  assign dut_out = {q, 1'b0, eff[0] ^ eff[1], q, 2'b00};
  assign dut_oe  = {eff[4], 1'b0, 1'b1, 1'b1, 2'b00};

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int sent   = 0;
  int seen   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit           pass;
    logic [NP-1:0] mask;
    int           fcnt;
    int           lat;
    string        req;
  } exp_t;
  exp_t exp_q[$];
  int   acc_q[$];

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    exp_t e;
    int   a;
    if (!rst && res_valid) begin
      if (exp_q.size() == 0 || acc_q.size() == 0) begin
        chk("R11", "unexpected result", 1, 0);
      end else begin
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        chk(e.req, "pass", res_pass, e.pass);
        chk(e.req, "mismatch", res_mismatch, e.mask);
        chk("R12", "fail_count", fail_count, e.fcnt);
        chk("R10", "latency", cyc - a, e.lat);
      end
      seen++;
    end
  end

  function automatic logic [NP*4-1:0] pk(input logic [3:0] p0, p1, p2, p3, p4, p5);
    return {p5, p4, p3, p2, p1, p0};
  endfunction

  task automatic run_vec(input logic [NP*4-1:0] syms, input int settle, input bit pass,
                         input logic [NP-1:0] mask, input int fcnt, input string req);
    exp_t e;
    @(negedge clk);
    rises = 0;
    vec_valid  = 1'b1;
    vec_syms   = syms;
    settle_cnt = settle[SW-1:0];
    while (!vec_ready) @(negedge clk);
    e.pass = pass; e.mask = mask; e.fcnt = fcnt; e.lat = 2 * settle + 7; e.req = req;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    acc_q.push_back(cyc);
    vec_valid = 1'b0;
    sent++;
    chk("R10", "ready low while busy", vec_ready, 0);
    while (seen < sent) @(negedge clk);
    chk("R7", "no contention", pin_drv_en & dut_oe, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "drive enables in reset", pin_drv_en, 0);
    chk("R1", "fail_count in reset", fail_count, 0);
    chk("R1", "res_valid in reset", res_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", vec_ready, 1);

    // V1: data 1 with C pulse on clock pin; register must take the new data (R3, R4)
    run_vec(pk(C1, CC, CH, CH, C0, CZ), 3, 1'b1, 6'b000000, 0, "R3");
    chk("R4", "C pin ends low", pin_drv[1], 0);
    chk("R4", "C pin enabled", pin_drv_en[1], 1);
    chk("R4", "C gives one rise", rises, 1);
    chk("R2", "level pins driven", {pin_drv_en[4], pin_drv_en[0], pin_drv[4], pin_drv[0]}, 4'b1101);

    // V2: clock pin released by don't-care, bidirectional pin read as output (R7, R8)
    run_vec(pk(C0, CX, CH, CL, C1, CH), 1, 1'b1, 6'b000000, 0, "R8");
    chk("R7", "don't-care releases pin", pin_drv_en[1], 0);
    chk("R7", "expectation releases pin", pin_drv_en[5], 0);

    // V3: U captures 0; wrong H on pin2 and Z on a driven pin5 fail (R6, R8, R12)
    run_vec(pk(C0, CU, CH, CH, C1, CZ), 2, 1'b0, 6'b100100, 1, "R8");
    chk("R6", "U ends high", pin_drv[1], 1);

    // V4: D falls, no capture; combinational pin3 sees new low clock (R6)
    run_vec(pk(C1, CD, CL, CH, C0, CZ), 0, 1'b1, 6'b000000, 1, "R6");
    chk("R6", "D ends low", pin_drv[1], 0);

    // V5: K from low start gives two rises, float releases enable pin (R5, R7)
    run_vec(pk(C1, CK, CH, CL, CF, CZ), 4, 1'b1, 6'b000000, 1, "R5");
    chk("R5", "K ends high", pin_drv[1], 1);
    chk("R5", "K rises", rises, 2);
    chk("R7", "float releases pin", pin_drv_en[4], 0);

    // V6: everything released; levels hold (R9)
    run_vec(pk(CX, CX, CH, CL, CX, CZ), 1, 1'b1, 6'b000000, 1, "R9");
    chk("R9", "data level held", pin_drv[0], 1);
    chk("R9", "clock level held", pin_drv[1], 1);
    chk("R9", "all released", pin_drv_en, 0);

    // V7: unused code is a don't-care; two expectations fail (R7, R8, R12)
    run_vec(pk(C0, CX, CL, CH, CBAD, CX), 2, 1'b0, 6'b001100, 2, "R7");
    chk("R7", "unused code releases pin", pin_drv_en[4], 0);

    // V8: zero settle, C from held-high released pin still one rise (R4, R10)
    run_vec(pk(C1, CC, CH, CH, C0, CZ), 0, 1'b1, 6'b000000, 2, "R4");
    chk("R4", "C rise count", rises, 1);
    chk("R11", "pulse ended", res_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule